// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Wake-on-Change

This block is the port register file of a small microcontroller core. It drives six pads through an output data latch and a direction register, and it returns pad levels to the CPU. The CPU uses three strobes on one 8-bit data bus. A port write loads the latch. A direction write loads the direction register, which has no read path. A port read returns the synchronized pad levels rather than the latch contents.

Bit 3 is input-only. The driver on bit 2 can be forced off by an option-control input. Pins assigned to an alternate function read back as 0. Bits 0, 1 and 3 each have a weak pull-up and take part in wake-on-change. Each of those two features has one global enable. When bit 3 serves as master clear, its pull-up is forced on and it takes no part in wake detection.

For wake detection, the block keeps a snapshot of the synchronized pins, taken at each port read. The block raises a sticky wake request when an enabled pin differs from that snapshot. The next port read or a reset clears the request.

Top module: `gpio_port6`

## Requirements
- R1: During and after reset, every direction bit is 1, so `pad_oe` reads 6'b000000. The output latch and `pad_out` are 6'b000000, and `wake_req` is 0.
- R2: A `dir_wr` strobe loads `cpu_wdata[5:0]` into the direction register. A 0 in bit i enables the driver (`pad_oe[i]`=1) and a 1 disables it. A direction write does not change `port_rdata`.
- R3: A `port_wr` strobe loads `cpu_wdata[5:0]` into the output latch, which appears on `pad_out` after that clock edge. The latch holds its value until the next `port_wr`.
- R4: `port_rdata[5:0]` carries the pad inputs through a two-flop synchronizer, not the latch. `port_rdata[7:6]` is always 0.
- R5: Bit 3 is input-only: `pad_oe[3]` stays 0 whatever its direction bit holds.
- R6: While `gp2_drv_off` is 1, `pad_oe[2]` is 0 regardless of direction bit 2.
- R7: A 1 in `alt_fn[i]` forces `port_rdata[i]` to 0.
- R8: `pad_pu[0]` and `pad_pu[1]` equal `pullup_en`. `pad_pu[3]` equals `pullup_en | mclr_mode`. Bits 2, 4 and 5 of `pad_pu` are 0.
- R9: While `wake_en` is 1, a difference between the synchronized level of bit 0, 1 or 3 and the snapshot taken at the last port read sets `wake_req` within three clock edges. Bit 3 is excluded while `mclr_mode` is 1. Bits 2, 4 and 5 never set it. The snapshot resets to 0.
- R10: `wake_req` stays set until a `port_rd` strobe, which clears it at the same edge that captures a new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wdata | input | 8 | CPU write data (working register) |
| port_wr | input | 1 | Output latch write strobe |
| dir_wr | input | 1 | Direction register write strobe |
| port_rd | input | 1 | Port read strobe (snapshot and wake clear) |
| port_rdata | output | 8 | Port read data |
| alt_fn | input | 6 | Per-pin alternate-function assignment |
| mclr_mode | input | 1 | Bit 3 acts as master clear |
| gp2_drv_off | input | 1 | Forces the bit 2 driver off |
| pullup_en | input | 1 | Global weak pull-up enable |
| wake_en | input | 1 | Global wake-on-change enable |
| pad_in | input | 6 | Raw pad input levels |
| pad_out | output | 6 | Output latch to pads |
| pad_oe | output | 6 | Per-pin driver enable |
| pad_pu | output | 6 | Per-pin weak pull-up enable |
| wake_req | output | 1 | Sticky wake request |

## Verification
The bench sets the latch opposite to the pad levels. A design that read back the latch would then return wrong data, and so would one that let masked alternate-function pins or bits 7:6 through. A direction write of all zeros exposes a design that drives bit 3, or that drives bit 2 while the option override is active. The wake tests toggle excluded pins. They toggle bit 3 in master-clear mode and toggle pins with the wake enable off. They release a pin back to its snapshot level. A design that widened the wake mask, lost the sticky behaviour or ignored the read-clear would show a wrong `wake_req`.

// File: rtl/gpio_port6.sv
module gpio_port6 #(
  parameter int NPIN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cpu_wdata,
  input  logic            port_wr,
  input  logic            dir_wr,
  input  logic            port_rd,
  output logic [7:0]      port_rdata,
  input  logic [NPIN-1:0] alt_fn,
  input  logic            mclr_mode,
  input  logic            gp2_drv_off,
  input  logic            pullup_en,
  input  logic            wake_en,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  output logic            wake_req
);

  localparam int PAD_BITS = 8 - NPIN;

  logic [NPIN-1:0] out_q, dir_q, sync1_q, pin_q, snap_q, wake_mask;
  logic            unused_hi;

  assign unused_hi = ^cpu_wdata[7:NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      if (port_wr) out_q <= cpu_wdata[NPIN-1:0];
      if (dir_wr)  dir_q <= cpu_wdata[NPIN-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      pin_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      pin_q   <= sync1_q;
    end
  end

  assign pad_out = out_q;

  always_comb begin
    pad_oe    = ~dir_q;
    pad_oe[3] = 1'b0;
    pad_oe[2] = ~dir_q[2] & ~gp2_drv_off;
  end

  assign port_rdata = {{PAD_BITS{1'b0}}, pin_q & ~alt_fn};

  always_comb begin
    pad_pu    = '0;
    pad_pu[0] = pullup_en;
    pad_pu[1] = pullup_en;
    pad_pu[3] = pullup_en | mclr_mode;
  end

  always_comb begin
    wake_mask    = '0;
    wake_mask[0] = wake_en;
    wake_mask[1] = wake_en;
    wake_mask[3] = wake_en & ~mclr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      wake_req <= 1'b0;
    end else if (port_rd) begin
      snap_q   <= pin_q;
      wake_req <= 1'b0;
    end else if (|((pin_q ^ snap_q) & wake_mask)) begin
      wake_req <= 1'b1;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(pad_out)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q)); // R2
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> !wake_req); // R10
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !port_rd) |=> wake_req); // R10
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en && !wake_req) |=> !wake_req); // R9
  AST_GP3_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> !pad_oe[3]); // R5

endmodule

// File: tb/test_gpio_port6.sv
module test_gpio_port6;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       port_wr = 0, dir_wr = 0, port_rd = 0;
  logic [7:0] port_rdata;
  logic [5:0] alt_fn = '0;
  logic       mclr_mode = 0, gp2_drv_off = 0, pullup_en = 0, wake_en = 0;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_out, pad_oe, pad_pu;
  logic       wake_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port6 i_gpio_port6 (
    .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata), .port_wr(port_wr),
    .dir_wr(dir_wr), .port_rd(port_rd), .port_rdata(port_rdata), .alt_fn(alt_fn),
    .mclr_mode(mclr_mode), .gp2_drv_off(gp2_drv_off), .pullup_en(pullup_en),
    .wake_en(wake_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .wake_req(wake_req));

  // {pad_in, alt_fn, expected port_rdata}
  localparam logic [19:0] VEC [8] = '{
    {6'h3F, 6'h00, 8'h3F}, {6'h15, 6'h00, 8'h15}, {6'h2A, 6'h00, 8'h2A},
    {6'h3F, 6'h05, 8'h3A}, {6'h3F, 6'h30, 8'h0F}, {6'h00, 6'h3F, 8'h00},
    {6'h2A, 6'h02, 8'h28}, {6'h09, 6'h00, 8'h09}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int kind, input logic [7:0] d);
    cpu_wdata = d;
    if (kind == 0) port_wr = 1; else if (kind == 1) dir_wr = 1; else port_rd = 1;
    @(negedge clk);
    port_wr = 0; dir_wr = 0; port_rd = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R1 oe in reset", {2'b0, pad_oe}, 8'h00);
    rst_n = 1;
    cyc(1);
    chk("R1 oe", {2'b0, pad_oe}, 8'h00);
    chk("R1 out", {2'b0, pad_out}, 8'h00);
    chk("R1 wake", {7'b0, wake_req}, 8'h00);

    strobe(0, 8'hC0);
    chk("R3 latch load", {2'b0, pad_out}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      strobe(0, {2'b11, ~VEC[i][19:14]});
      pad_in = VEC[i][19:14];
      alt_fn = VEC[i][13:8];
      cyc(3);
      chk("R4 R7 read pins", port_rdata, VEC[i][7:0]);
    end
    alt_fn = '0;

    strobe(0, 8'h2D);
    cyc(3);
    chk("R3 latch hold", {2'b0, pad_out}, 8'h2D);
    pad_in = 6'h00;
    cyc(3);
    chk("R4 not latch", port_rdata, 8'h00);
    strobe(1, 8'h00);
    chk("R2 R5 dir all out", {2'b0, pad_oe}, 8'h37);
    chk("R2 no read path", port_rdata, 8'h00);
    gp2_drv_off = 1;
    #1 chk("R6 gp2 override", {2'b0, pad_oe}, 8'h33);
    gp2_drv_off = 0;
    strobe(1, 8'h2A);
    chk("R2 dir pattern", {2'b0, pad_oe}, 8'h15);

    #1 chk("R8 pu off", {2'b0, pad_pu}, 8'h00);
    mclr_mode = 1;
    #1 chk("R8 mclr pu", {2'b0, pad_pu}, 8'h08);
    pullup_en = 1; mclr_mode = 0;
    #1 chk("R8 pu on", {2'b0, pad_pu}, 8'h0B);
    cyc(1);

    wake_en = 1;
    strobe(2, 8'h00);
    cyc(1);
    chk("R10 read clears", {7'b0, wake_req}, 8'h00);
    pad_in = 6'h34;
    cyc(5);
    chk("R9 excluded pins", {7'b0, wake_req}, 8'h00);
    pad_in = 6'h35;
    cyc(4);
    chk("R9 bit0 wake", {7'b0, wake_req}, 8'h01);
    pad_in = 6'h34;
    cyc(4);
    chk("R10 sticky", {7'b0, wake_req}, 8'h01);
    strobe(2, 8'h00);
    cyc(1);
    chk("R10 cleared", {7'b0, wake_req}, 8'h00);
    mclr_mode = 1;
    pad_in = 6'h3C;
    cyc(5);
    chk("R9 mclr excludes bit3", {7'b0, wake_req}, 8'h00);
    strobe(2, 8'h00);
    mclr_mode = 0;
    pad_in = 6'h34;
    cyc(4);
    chk("R9 bit3 wake", {7'b0, wake_req}, 8'h01);
    strobe(2, 8'h00);
    wake_en = 0;
    pad_in = 6'h36;
    cyc(5);
    chk("R9 global off", {7'b0, wake_req}, 8'h00);
    strobe(2, 8'h00);
    wake_en = 1;
    cyc(4);
    chk("R9 fresh snapshot", {7'b0, wake_req}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule